// File: doc/BRIEF.md
# Device-Side Power-State Handshake Controller

This block sits at the device end of a four-wire power-state handshake. An external power controller drives a request line and a 4-bit requested-state code. The device answers on an accept line, a deny line and a 16-bit activity hint. The device has two power states, ON and OFF. It takes its initial state from the state code present when reset is released. It then answers each request with exactly one accept or one deny. The answer is held until the controller drops the request.

A move from ON to OFF never fails just because traffic is still in flight. The device waits for its internal traffic-idle indication and only then accepts. A power-down request is refused when PHY low-power handling is enabled and the PHY has refused its own power-down. The request and state code cross into the device clock through two-flop synchronizers. Reset is applied asynchronously and released through a synchronizer. Gating of the clock itself is left to the surrounding logic.

Top module: `pwr_hs_dev`

## Requirements
- R1: While reset is asserted, and until the initial state has been loaded, accept and deny are low, cur_on_o is 0 and the hint is 0x0000.
- R2: On reset release the device loads its state from state_i. A code of 0x8 gives ON (cur_on_o = 1). Every other code, including 0x0, gives OFF (cur_on_o = 0).
- R3: Accept rises only while the synchronized request is high and deny is low. Accept falls only while the request is low and deny is low.
- R4: Deny rises only while the synchronized request is high and accept is low. Deny falls only while the request is low and accept is low. Accept and deny are never high together.
- R5: A request with code 0x8 while OFF is accepted. The state becomes ON and the hint becomes 0x0100 no later than the cycle in which accept rises.
- R6: A request with code 0x0 while ON, with traffic idle and no PHY refusal, is accepted. The state becomes OFF and the hint becomes 0x0000.
- R7: A request with code 0x0 while ON and traffic busy raises neither accept nor deny, and the state stays ON, until idle_i goes high. Accept follows one cycle after idle_i rises.
- R8: A request with code 0x0 while ON is denied when phy_lp_en_i and phy_pd_deny_i are both high, including while waiting for traffic to drain. The state stays ON. When phy_lp_en_i is low, phy_pd_deny_i has no effect.
- R9: A request for the state the device already holds, or with any code other than 0x8 or 0x0, is denied and the state does not change.
- R10: Accept or deny appears at the third rising clock edge after req_i rises. It clears at the third rising edge after req_i falls.
- R11: Any state change is visible on cur_on_o and active_o no later than the cycle in which accept rises. The state never changes without an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Power-state transition request from the controller (asynchronous) |
| state_i | input | 4 | Requested state code: 0x8 ON, 0x0 OFF (asynchronous) |
| idle_i | input | 1 | Internal traffic has drained (device clock domain) |
| phy_lp_en_i | input | 1 | PHY low-power handling enabled |
| phy_pd_deny_i | input | 1 | PHY refused the device's power-down request |
| accept_o | output | 1 | Transition accepted and complete |
| deny_o | output | 1 | Transition refused |
| active_o | output | 16 | Activity hint: 0x0100 when ON, 0x0000 when OFF |
| cur_on_o | output | 1 | Current power state, 1 = ON |

## Verification
A response to a request edge is due three rising edges after the request changes: two synchronizer flops plus the state register. The bench drives inputs on falling edges. It confirms the response is still absent after two edges and present after the third. A drain-gated accept or a PHY-driven deny is due one edge after idle_i or the PHY refusal changes, and is sampled at the falling edge that follows. The initial state is due three edges after reset release, and the vector walk waits well past every latency before comparing.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

  localparam int CODE_W = 4;
  localparam int HINT_W = 16;

  localparam logic [CODE_W-1:0] CODE_ON  = 4'h8;
  localparam logic [CODE_W-1:0] CODE_OFF = 4'h0;

  localparam logic [HINT_W-1:0] HINT_ON  = 16'h0100;
  localparam logic [HINT_W-1:0] HINT_OFF = 16'h0000;

  typedef enum logic [2:0] {
    HS_LOAD  = 3'd0,
    HS_QUIET = 3'd1,
    HS_DRAIN = 3'd2,
    HS_ACK   = 3'd3,
    HS_NAK   = 3'd4
  } hs_state_e;

endpackage

// File: rtl/pwr_hs_rst_sync.sv
module pwr_hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_hs_sync.sv
module pwr_hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_hs_fsm.sv
module pwr_hs_fsm
  import pwr_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              req_s,
  input  logic [CODE_W-1:0] code_s,
  input  logic              idle_i,
  input  logic              phy_lp_en_i,
  input  logic              phy_pd_deny_i,
  output logic              accept_o,
  output logic              deny_o,
  output logic              on_o,
  output logic              loaded_o
);

  hs_state_e st_q, st_d;
  logic      on_q, on_d, on_en;
  logic      pd_block;

  assign pd_block = phy_lp_en_i & phy_pd_deny_i;

  always_comb begin
    st_d = st_q;
    on_d = on_q;
    case (st_q)
      HS_LOAD: begin
        on_d = (code_s == CODE_ON);
        st_d = HS_QUIET;
      end
      HS_QUIET: begin
        if (req_s) begin
          if (code_s == CODE_ON) begin
            if (on_q) begin
              st_d = HS_NAK;
            end else begin
              st_d = HS_ACK;
              on_d = 1'b1;
            end
          end else if (code_s == CODE_OFF) begin
            if (!on_q || pd_block) begin
              st_d = HS_NAK;
            end else if (idle_i) begin
              st_d = HS_ACK;
              on_d = 1'b0;
            end else begin
              st_d = HS_DRAIN;
            end
          end else begin
            st_d = HS_NAK;
          end
        end
      end
      HS_DRAIN: begin
        if (pd_block) begin
          st_d = HS_NAK;
        end else if (idle_i) begin
          st_d = HS_ACK;
          on_d = 1'b0;
        end
      end
      HS_ACK: begin
        if (!req_s) st_d = HS_QUIET;
      end
      HS_NAK: begin
        if (!req_s) st_d = HS_QUIET;
      end
      default: st_d = HS_LOAD;
    endcase
  end

  assign on_en = (on_d != on_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= HS_LOAD;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      on_q <= 1'b0;
    end else if (on_en) begin
      on_q <= on_d;
    end
  end

  assign accept_o = (st_q == HS_ACK);
  assign deny_o   = (st_q == HS_NAK);
  assign on_o     = on_q;
  assign loaded_o = (st_q != HS_LOAD);

  // R3: accept edges follow the request/deny ordering rules
  a_r3_acc_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(accept_o) |-> $past(req_s) && !$past(deny_o));
  a_r3_acc_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(accept_o) |-> !$past(req_s) && !$past(deny_o));

  // R4: deny edges follow the request/accept ordering rules
  a_r4_deny_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(deny_o) |-> $past(req_s) && !$past(accept_o));
  a_r4_deny_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(deny_o) |-> !$past(req_s) && !$past(accept_o));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(accept_o && deny_o));

  // R11: after loading, the power state moves only together with an accept
  a_r11_change_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(loaded_o) && (on_o != $past(on_o))) |-> accept_o);

  // R7: power-down is accepted only once traffic is idle
  a_r7_idle_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(accept_o) && !on_o) |-> $past(idle_i));

  // R8: a PHY refusal with low-power enabled never lets power-down through
  a_r8_phy_block: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(accept_o) && !on_o) |-> !($past(phy_lp_en_i) && $past(phy_pd_deny_i)));

endmodule

// File: rtl/pwr_hs_dev.sv
module pwr_hs_dev
  import pwr_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CODE_W-1:0] state_i,
  input  logic              idle_i,
  input  logic              phy_lp_en_i,
  input  logic              phy_pd_deny_i,
  output logic              accept_o,
  output logic              deny_o,
  output logic [HINT_W-1:0] active_o,
  output logic              cur_on_o
);

  localparam int XW = CODE_W + 1;

  logic              rst_sync_n;
  logic [XW-1:0]     xin, xout;
  logic              req_s;
  logic [CODE_W-1:0] code_s;
  logic              on_w;
  logic              loaded_w;

  pwr_hs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign xin = {req_i, state_i};

  pwr_hs_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (xin),
    .q_o   (xout)
  );

  assign req_s  = xout[XW-1];
  assign code_s = xout[CODE_W-1:0];

  pwr_hs_fsm u_fsm (
    .clk           (clk),
    .rst_sync_n    (rst_sync_n),
    .req_s         (req_s),
    .code_s        (code_s),
    .idle_i        (idle_i),
    .phy_lp_en_i   (phy_lp_en_i),
    .phy_pd_deny_i (phy_pd_deny_i),
    .accept_o      (accept_o),
    .deny_o        (deny_o),
    .on_o          (on_w),
    .loaded_o      (loaded_w)
  );

  assign cur_on_o = on_w;
  assign active_o = on_w ? HINT_ON : HINT_OFF;

  // R1: no handshake response until the initial state is loaded
  a_r1_quiet_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !loaded_w |-> !accept_o && !deny_o);

endmodule

// File: tb/pwr_hs_dev_tb.sv
module pwr_hs_dev_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [3:0]  state_i;
  logic        idle_i;
  logic        phy_lp_en_i;
  logic        phy_pd_deny_i;
  logic        accept_o;
  logic        deny_o;
  logic [15:0] active_o;
  logic        cur_on_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_hs_dev u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .state_i       (state_i),
    .idle_i        (idle_i),
    .phy_lp_en_i   (phy_lp_en_i),
    .phy_pd_deny_i (phy_pd_deny_i),
    .accept_o      (accept_o),
    .deny_o        (deny_o),
    .active_o      (active_o),
    .cur_on_o      (cur_on_o)
  );

  // {code[3:0], idle, lp_en, pd_deny, exp_acc, exp_deny, exp_on}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 ON->OFF
    {4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 already OFF
    {4'h8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 OFF->ON
    {4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 already ON
    {4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 invalid code
    {4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R8 PHY refusal
    {4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R8 refusal ignored
    {4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R9 invalid code
    {4'h8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R5 power-up not blocked
    {4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}   // R6 lp enabled, PHY agrees
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] code);
    rst_n   = 1'b0;
    req_i   = 1'b0;
    state_i = code;
    ticks(3);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    summary();
  end

  initial begin
    idle_i = 1'b1; phy_lp_en_i = 1'b0; phy_pd_deny_i = 1'b0;
    @(negedge clk);

    // R1: outputs quiet in reset
    do_reset(4'h8);
    rst_n = 1'b0;
    ticks(1);
    check("R1 acc in reset",  accept_o, 0);
    check("R1 deny in reset", deny_o, 0);
    check("R1 hint in reset", active_o, 16'h0000);
    check("R1 state in reset", cur_on_o, 0);

    // R2: initial OFF from 0x0, then from an invalid code
    do_reset(4'h0); ticks(5);
    check("R2 init 0x0", cur_on_o, 0);
    do_reset(4'h5); ticks(5);
    check("R2 init 0x5", cur_on_o, 0);
    check("R2 hint 0x5", active_o, 16'h0000);
    // R2: initial ON; R1: state not loaded before third edge
    do_reset(4'h8);
    ticks(2);
    check("R1 not yet loaded", cur_on_o, 0);
    ticks(3);
    check("R2 init 0x8", cur_on_o, 1);
    check("R2 hint ON", active_o, 16'h0100);

    // Vector walk from ON
    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VEC[i];
      state_i = v[9:6]; idle_i = v[5]; phy_lp_en_i = v[4]; phy_pd_deny_i = v[3];
      ticks(2);
      req_i = 1'b1;
      ticks(6);
      check($sformatf("R3/R4 vec%0d accept", i), accept_o, v[2]);
      check($sformatf("R4 vec%0d deny", i),      deny_o, v[1]);
      check($sformatf("R11 vec%0d state", i),    cur_on_o, v[0]);
      check($sformatf("R11 vec%0d hint", i),     active_o, v[0] ? 16'h0100 : 16'h0000);
      req_i = 1'b0;
      ticks(6);
      check($sformatf("R3 vec%0d release", i), {accept_o, deny_o}, 2'b00);
    end
    phy_lp_en_i = 1'b0; phy_pd_deny_i = 1'b0; idle_i = 1'b1;

    // R10: exact response latency (device is OFF here)
    state_i = 4'h8; ticks(2);
    req_i = 1'b1;
    ticks(2);
    check("R10 accept not before edge 3", accept_o, 0);
    ticks(1);
    check("R10 accept at edge 3", accept_o, 1);
    check("R5 state with accept", cur_on_o, 1);
    req_i = 1'b0;
    ticks(2);
    check("R10 accept held to edge 3", accept_o, 1);
    ticks(1);
    check("R10 accept clear at edge 3", accept_o, 0);

    // R7: drain wait
    state_i = 4'h0; idle_i = 1'b0; ticks(2);
    req_i = 1'b1;
    ticks(12);
    check("R7 no answer while busy", {accept_o, deny_o}, 2'b00);
    check("R7 still ON while busy", cur_on_o, 1);
    idle_i = 1'b1;
    ticks(1);
    check("R7 accept after idle", accept_o, 1);
    check("R7 OFF after drain", cur_on_o, 0);
    req_i = 1'b0; ticks(6);

    // R8: refusal arriving during drain
    state_i = 4'h8; ticks(2); req_i = 1'b1; ticks(6); req_i = 1'b0; ticks(6);
    state_i = 4'h0; idle_i = 1'b0; phy_lp_en_i = 1'b1; ticks(2);
    req_i = 1'b1;
    ticks(8);
    check("R8 waiting before refusal", {accept_o, deny_o}, 2'b00);
    phy_pd_deny_i = 1'b1;
    ticks(1);
    check("R8 deny during drain", deny_o, 1);
    check("R8 state kept ON", cur_on_o, 1);
    idle_i = 1'b1;
    ticks(3);
    check("R4 deny held while req high", {accept_o, deny_o}, 2'b01);
    req_i = 1'b0; ticks(6);
    check("R4 deny released", deny_o, 0);

    summary();
  end

endmodule